// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between a two-wire bus slave controller and a nonvolatile byte array. While a write transaction is open, the controller hands over data bytes one at a time, each with a strobe and a full byte address. The bytes collect in a one-page staging buffer. A bit mask records which page slots were loaded. The page itself is taken from the first byte of the transaction. Later bytes choose only their slot within that page.

When the controller reports a stop that closes the transaction, the block checks the hardware protect input against the buffered page and then launches a self-timed commit. During the commit it walks the page slots in ascending order and emits one array write for each loaded slot. It holds `busy` high for a fixed number of clock cycles, which the controller uses to keep the bus side silent. If the transaction ends in a repeated start instead of a stop, or the page is protected, the buffer is thrown away and nothing is written.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy` and `arr_we` are low and the buffer holds no loaded slots.
- R2: A `wr_stb` while idle stores `wr_data` in slot `wr_addr[4:0]`. The page (`wr_addr[12:5]`) is captured from the first stored byte of the transaction. A second store to the same slot replaces the earlier byte.
- R3: A `stop_seen` pulse while idle, with at least one loaded slot and no protection block, raises `busy` on the next clock. `busy` then stays high for exactly `COMMIT_CYCLES` cycles.
- R4: During a commit, exactly one array write is issued per loaded slot, in ascending slot order, at address `{page, slot}` and with the last byte stored there. Slots that were not loaded are never written.
- R5: A `stop_seen` with no loaded slots starts no commit and leaves `busy` low.
- R6: A `start_seen` pulse while idle discards every loaded slot, so a following stop starts no commit.
- R7: `wp` is sampled when the stop arrives. If it is high and the page lies in the top quarter (`wr_addr[12:11] == 2'b11`, addresses 0x1800 to 0x1FFF), no array write and no busy follow, and the buffer is discarded. A change of `wp` during a commit has no effect on it.
- R8: With `wp` low, the top quarter commits normally. With `wp` high, pages below 0x1800 still commit.
- R9: While `busy` is high, `wr_stb`, `stop_seen` and `start_seen` are ignored. Nothing they carry is stored or acted on.
- R10: When a commit ends, the buffer is empty. The next transaction writes only the slots it loads itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle strobe: data byte received from the bus |
| wr_addr | input | 13 | Byte address of the received data |
| wr_data | input | 8 | Received data byte |
| stop_seen | input | 1 | One-cycle pulse: transaction closed by a stop |
| start_seen | input | 1 | One-cycle pulse: transaction closed by a repeated start |
| wp | input | 1 | Hardware write-protect level |
| busy | output | 1 | Commit in progress; the bus side must stay inactive |
| arr_we | output | 1 | Array write enable, one cycle per byte |
| arr_addr | output | 13 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench targets several corner cases, each with a distinct failure mode.
- A full page shows whether the slot scan stops after the last slot. A scan that wrapped would rewrite slot 0.
- A repeated store to one slot catches a buffer that kept the first byte or wrote the slot twice.
- Protected and unprotected pages on both sides of 0x1800, together with a `wp` toggle in the middle of a commit, expose a design that compares the wrong address bits or samples `wp` late.
- Strobes and pulses injected during `busy`, followed by a one-byte transaction, reveal a buffer that still loads while committing or that is not cleared afterwards.
- A busy interval one cycle short or long fails the exact interval count.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_SCAN = 2'd1,
      SEQ_HOLD = 2'd2
   } seq_state_e;

   // top quarter of the array: the two highest page bits both set
   function automatic logic in_top_quarter(input logic [1:0] hi_bits);
      return hi_bits == 2'b11;
   endfunction

endpackage

// File: rtl/pgwr_page_buffer.sv
module pgwr_page_buffer #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int PAGE_W     = 8,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [PAGE_W-1:0] ld_page,
   input  logic [OFF_W-1:0]  ld_off,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              clr,
   input  logic              hold,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid,
   output logic [PAGE_W-1:0] page
);

   logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid_q;

   genvar gi;
   generate
      for (gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[gi] <= '0;
            else if (ld && ld_off == OFF_W'(gi))
               slot_q[gi] <= ld_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         page    <= '0;
      end else if (clr) begin
         valid_q <= '0;
      end else if (ld) begin
         valid_q[ld_off] <= 1'b1;
         if (valid_q == '0)
            page <= ld_page;
      end
   end

   assign rd_data   = slot_q[rd_off];
   assign rd_valid  = valid_q[rd_off];
   assign any_valid = |valid_q;

   // R9
   hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clr) |=> $stable(valid_q));

   // R4
   hold_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(page));

endmodule

// File: rtl/pgwr_protect.sv
module pgwr_protect #(
   parameter int PAGE_W     = 8,
   parameter bit PROTECT_EN = 1'b1
) (
   input  logic [PAGE_W-1:0] page,
   input  logic              wp,
   output logic              blocked
);

   generate
      if (PROTECT_EN) begin : g_prot
         assign blocked = wp && pgwr_pkg::in_top_quarter(page[PAGE_W-1 -: 2]);
      end else begin : g_open
         assign blocked = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pgwr_commit_seq.sv
module pgwr_commit_seq #(
   parameter int PAGE_BYTES    = 32,
   parameter int COMMIT_CYCLES = 2_500_000,
   localparam int OFF_W        = $clog2(PAGE_BYTES),
   localparam int CNT_W        = $clog2(COMMIT_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output logic             busy,
   output logic             scan_act,
   output logic [OFF_W-1:0] scan_off,
   output logic             done
);

   import pgwr_pkg::*;

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         cnt_q    <= '0;
         scan_off <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (go) begin
               state_q  <= SEQ_SCAN;
               cnt_q    <= CNT_W'(COMMIT_CYCLES - 1);
               scan_off <= '0;
            end
            SEQ_SCAN: begin
               scan_off <= scan_off + 1'b1;
               cnt_q    <= cnt_q - 1'b1;
               if (cnt_q == '0)
                  state_q <= SEQ_IDLE;
               else if (scan_off == LAST_OFF)
                  state_q <= SEQ_HOLD;
            end
            SEQ_HOLD: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == '0)
                  state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = state_q != SEQ_IDLE;
   assign scan_act = state_q == SEQ_SCAN;
   assign done     = busy && cnt_q == '0;

   // R3
   go_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go) |=> (busy && scan_off == '0));

   // R4
   scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_act && scan_off == LAST_OFF) |=> !scan_act);

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
   parameter int ADDR_W        = 13,
   parameter int DATA_W        = 8,
   parameter int PAGE_BYTES    = 32,
   parameter int COMMIT_CYCLES = 2_500_000,
   parameter bit PROTECT_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              stop_seen,
   input  logic              start_seen,
   input  logic              wp,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata
);

   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFF_W;

   generate
      if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (COMMIT_CYCLES < PAGE_BYTES) begin : g_bad_cycles
         $error("COMMIT_CYCLES must cover one scan of the page");
      end
      if (PAGE_W < 2) begin : g_bad_addr
         $error("ADDR_W too narrow for a quarter split");
      end
   endgenerate

   logic              ld, clr, go, blocked, done, scan_act;
   logic              any_valid, rd_valid;
   logic [OFF_W-1:0]  scan_off;
   logic [PAGE_W-1:0] page;
   logic [DATA_W-1:0] rd_data;
   logic              wp_at_go;

   assign ld  = wr_stb && !busy;
   assign go  = stop_seen && !busy && any_valid && !blocked;
   assign clr = done || (!busy && !go && (stop_seen || start_seen));

   pgwr_page_buffer #(
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES),
      .PAGE_W     (PAGE_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ld),
      .ld_page   (wr_addr[ADDR_W-1:OFF_W]),
      .ld_off    (wr_addr[OFF_W-1:0]),
      .ld_data   (wr_data),
      .clr       (clr),
      .hold      (busy),
      .rd_off    (scan_off),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .any_valid (any_valid),
      .page      (page)
   );

   pgwr_protect #(
      .PAGE_W     (PAGE_W),
      .PROTECT_EN (PROTECT_EN)
   ) u_prot (
      .page    (page),
      .wp      (wp),
      .blocked (blocked)
   );

   pgwr_commit_seq #(
      .PAGE_BYTES    (PAGE_BYTES),
      .COMMIT_CYCLES (COMMIT_CYCLES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .busy     (busy),
      .scan_act (scan_act),
      .scan_off (scan_off),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wp_at_go <= 1'b0;
      else if (go)
         wp_at_go <= wp;
   end

   assign arr_we    = scan_act && rd_valid;
   assign arr_addr  = {page, scan_off};
   assign arr_wdata = rd_data;

   // R4
   we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R3
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_seen));

   // R7
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && PROTECT_EN) |->
         !(wp_at_go && pgwr_pkg::in_top_quarter(arr_addr[ADDR_W-1 -: 2])));

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_idle_chk: assert (!arr_we);
      end
   end

endmodule

// File: tb/pgwr_commit_tb.sv
module pgwr_commit_tb;

   localparam int CYC = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [12:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        stop_seen = 1'b0;
   logic        start_seen = 1'b0;
   logic        wp = 1'b0;
   logic        busy, arr_we;
   logic [12:0] arr_addr;
   logic [7:0]  arr_wdata;

   int total = 0;
   int bad = 0;

   logic [7:0] exp_page;
   logic       exp_valid [32];
   logic [7:0] exp_data [32];
   bit         exp_any;

   always #2 clk = ~clk;

   pgwr_commit #(.COMMIT_CYCLES(CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .stop_seen(stop_seen), .start_seen(start_seen),
      .wp(wp), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit protected_page(input logic [7:0] pg, input logic w);
      return w && pg[7:6] == 2'b11;
   endfunction

   function automatic int count_valid();
      int n = 0;
      for (int i = 0; i < 32; i++) if (exp_valid[i]) n++;
      return n;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 32; i++) begin
         exp_valid[i] = 1'b0;
         exp_data[i]  = '0;
      end
      exp_any = 1'b0;
   endtask

   task automatic put(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      if (!exp_any) exp_page = a[12:5];
      exp_any = 1'b1;
      exp_valid[a[4:0]] = 1'b1;
      exp_data[a[4:0]]  = d;
   endtask

   // close with stop, observe the commit; inject drives noise during busy
   task automatic close_stop(input string req, input bit inject, input bit flip_wp);
      bit go;
      int nb = 0, nw = 0, ptr = 0, nexp;
      go   = exp_any && !protected_page(exp_page, wp);
      nexp = go ? count_valid() : 0;
      @(negedge clk);
      stop_seen = 1'b1;
      @(negedge clk);
      stop_seen = 1'b0;
      chk(busy == go, req, "busy after stop", int'(busy), int'(go));
      while (busy && nb < CYC + 10) begin
         nb++;
         if (arr_we) begin
            while (ptr < 32 && !exp_valid[ptr]) ptr++;
            chk(arr_addr == {exp_page, 5'(ptr)}, "R4", "write addr",
                int'(arr_addr), int'({exp_page, 5'(ptr)}));
            chk(arr_wdata == exp_data[ptr & 31], "R4", "write data",
                int'(arr_wdata), int'(exp_data[ptr & 31]));
            ptr++;
            nw++;
         end
         if (inject) begin
            wr_stb = 1'b1; wr_addr = {exp_page, 5'd7}; wr_data = 8'hEE;
            stop_seen = nb[0]; start_seen = ~nb[0];
         end
         if (flip_wp) wp = 1'b1;
         @(negedge clk);
      end
      wr_stb = 1'b0; stop_seen = 1'b0; start_seen = 1'b0;
      chk(nb == (go ? CYC : 0), "R3", "busy length", nb, go ? CYC : 0);
      chk(nw == nexp, "R4", "write count", nw, nexp);
      model_clear();
   endtask

   task automatic close_start();
      @(negedge clk);
      start_seen = 1'b1;
      @(negedge clk);
      start_seen = 1'b0;
      chk(!busy, "R6", "busy after repeated start", int'(busy), 0);
      model_clear();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      model_clear();
      exp_page = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !arr_we, "R1", "outputs in reset", int'({busy, arr_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !arr_we, "R1", "outputs after reset", int'({busy, arr_we}), 0);
      close_stop("R1", 1'b0, 1'b0);  // empty buffer after reset: no commit

      // R2 single byte
      put(13'h0005, 8'h3C);
      close_stop("R2", 1'b0, 1'b0);

      // full page, ascending (R4 scan end)
      for (int i = 0; i < 32; i++) put({8'h10, 5'(i)}, 8'(i * 7 + 1));
      close_stop("R4", 1'b0, 1'b0);

      // R2 overwrite the same slot; later bytes keep the first page
      put(13'h0243, 8'h11);
      put(13'h0243, 8'h99);
      put(13'h0FF0, 8'h55);
      close_stop("R2", 1'b0, 1'b0);

      // R7 protected top quarter is dropped and the buffer discarded
      wp = 1'b1;
      put(13'h1800, 8'hA1);
      put(13'h1801, 8'hA2);
      close_stop("R7", 1'b0, 1'b0);
      close_stop("R7", 1'b0, 1'b0);

      // R8 just below the boundary with wp high
      put(13'h17FF, 8'hB7);
      close_stop("R8", 1'b0, 1'b0);
      // R8 top quarter with wp low
      wp = 1'b0;
      put(13'h1FFF, 8'hC3);
      put(13'h1FE0, 8'hC4);
      close_stop("R8", 1'b0, 1'b0);

      // R7 wp rising mid-commit has no effect
      put(13'h1C02, 8'hD1);
      close_stop("R7", 1'b0, 1'b1);
      wp = 1'b0;

      // R6 repeated start discards
      put(13'h0100, 8'h42);
      put(13'h0101, 8'h43);
      close_start();
      close_stop("R6", 1'b0, 1'b0);

      // R5 empty stop
      close_stop("R5", 1'b0, 1'b0);

      // R9 noise during busy; R10 buffer empty afterwards
      put(13'h0060, 8'h71);
      close_stop("R9", 1'b1, 1'b0);
      put(13'h0081, 8'h72);
      close_stop("R10", 1'b0, 1'b0);

      // constrained random transactions
      for (int t = 0; t < 24; t++) begin
         int n;
         logic [7:0] pg;
         pg = 8'($urandom_range(0, 255));
         n  = $urandom_range(1, 32);
         wp = 1'($urandom_range(0, 1));
         for (int k = 0; k < n; k++)
            put({pg, 5'($urandom_range(0, 31))}, 8'($urandom_range(0, 255)));
         if ($urandom_range(0, 5) == 0) begin
            close_start();
            close_stop("R6", 1'b0, 1'b0);
         end else begin
            close_stop("R4", 1'b0, 1'b0);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule